// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer

This block runs single read and write transactions on an external asynchronous static RAM from a synchronous clock domain. The RAM has three active-low controls (chip select, write strobe and output enable) and one shared data bus. That bus is split at the block's edge into a drive value, a drive enable and a sampled input. The pad ring or the board model resolves them into the physical tri-state wire.

The user side uses a valid/ready request carrying an address, write data and a write flag. Read results return as a data word with a one-cycle valid strobe. Each transaction runs through three timed phases: an address (and data) setup phase, a strobe phase and a hold phase. All three are counted in clock cycles and set by parameters. The write strobe width and the read access wait are set separately. Ready stays low for the whole transaction, so the spacing between successive memory operations is never shorter than the sum of the three phases.

Top module: `asram_seq`

## Requirements
- R1: After reset, chip select, write strobe and output enable are all high (inactive), the controller does not drive the data bus, request ready is high and the response valid is low.
- R2: A request is taken only in a cycle where request ready is high. A request presented while ready is low starts no transaction, and the memory address output does not change while ready is low.
- R3: Write strobe and output enable are never low in the same cycle, and chip select is low in every cycle where either of them is low.
- R4: The memory address (and, for a write, the driven data) appears when ready falls. Chip select falls exactly SETUP_CYC cycles after ready falls.
- R5: On a write, the write strobe and chip select stay low for exactly PULSE_CYC cycles, and the controller drives the data bus in every one of those cycles.
- R6: After the strobes return high, the address, and for a write the driven data, are held unchanged for exactly HOLD_CYC cycles before ready returns high.
- R7: On a read, output enable and chip select stay low for exactly WAIT_CYC cycles. The controller's bus drive is off in all of those cycles and in the cycle just before output enable falls.
- R8: Read data is sampled from the bus at the end of the last wait cycle. It is presented on the response data with a response valid that is high for exactly one cycle, the cycle in which output enable has just returned high.
- R9: Ready stays low for exactly SETUP_CYC + PULSE_CYC + HOLD_CYC cycles for a write and SETUP_CYC + WAIT_CYC + HOLD_CYC cycles for a read, and is high again in the next cycle.
- R10: Each of the four phase counts must be at least 1, and the address and data widths at least 1. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transaction request |
| req_ready | output | 1 | Controller idle; request taken when both high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Transaction address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle strobe for read data |
| rsp_rdata | output | DW | Read data |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | AW | Memory address |
| mem_dq_o | output | DW | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable (1 = controller drives) |
| mem_dq_i | input | DW | Sampled data bus |

## Verification
The bench builds the block with an 8-bit address, a 16-bit word, a setup of 2, a write pulse of 3, a read wait of 2 and a hold of 1 cycle. Because the pulse and the wait differ, a design that swaps the write and read strobe lengths, or miscounts any phase by one, produces a ready-low run or strobe width the bench can tell apart. The 8-bit address lets the bench reach both the lowest and the highest word and check reads of words never written. The two-cycle setup separates the cycle in which ready falls from the cycle in which chip select falls.

// File: rtl/asram_seq_pkg.sv
package asram_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } asram_phase_e;

   function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                           input int unsigned c, input int unsigned d);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/asram_phase_timer.sv
// Down-counter that times one phase; last is high in the final cycle of a phase.
module asram_phase_timer #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          last
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last = (cnt_q == '0);

endmodule

// File: rtl/asram_seq_fsm.sv
// Phase sequencer. Strobes and ready come straight from flops loaded with the
// decode of the next phase, so they change only at clock edges.
module asram_seq_fsm
   import asram_seq_pkg::*;
#(
   parameter int SETUP_CYC = 2,
   parameter int PULSE_CYC = 3,
   parameter int WAIT_CYC  = 2,
   parameter int HOLD_CYC  = 1,
   parameter int CW        = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic          last,
   output logic          load,
   output logic [CW-1:0] load_val,
   output logic          accept,
   output logic          capture,
   output logic          ready,
   output logic          cs_n,
   output logic          we_n,
   output logic          oe_n,
   output logic          dq_oe
);

   asram_phase_e state_q, state_d;
   logic         wr_q, wr_d;

   always_comb begin
      state_d  = state_q;
      wr_d     = wr_q;
      load     = 1'b0;
      load_val = '0;
      unique case (state_q)
         PH_IDLE: begin
            if (req_valid) begin
               state_d  = PH_SETUP;
               wr_d     = req_write;
               load     = 1'b1;
               load_val = CW'(SETUP_CYC - 1);
            end
         end
         PH_SETUP: begin
            if (last) begin
               state_d  = PH_STROBE;
               load     = 1'b1;
               load_val = wr_q ? CW'(PULSE_CYC - 1) : CW'(WAIT_CYC - 1);
            end
         end
         PH_STROBE: begin
            if (last) begin
               state_d  = PH_HOLD;
               load     = 1'b1;
               load_val = CW'(HOLD_CYC - 1);
            end
         end
         default: begin
            if (last) state_d = PH_IDLE;
         end
      endcase
   end

   assign accept  = (state_q == PH_IDLE) && req_valid;
   assign capture = (state_q == PH_STROBE) && last && !wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PH_IDLE;
         wr_q    <= 1'b0;
         ready   <= 1'b1;
         cs_n    <= 1'b1;
         we_n    <= 1'b1;
         oe_n    <= 1'b1;
         dq_oe   <= 1'b0;
      end else begin
         state_q <= state_d;
         wr_q    <= wr_d;
         ready   <= (state_d == PH_IDLE);
         cs_n    <= !(state_d == PH_STROBE);
         we_n    <= !((state_d == PH_STROBE) && wr_d);
         oe_n    <= !((state_d == PH_STROBE) && !wr_d);
         dq_oe   <= (state_d != PH_IDLE) && wr_d;
      end
   end

endmodule

// File: rtl/asram_seq_dp.sv
// Address/data holding registers and read capture.
module asram_seq_dp #(
   parameter int AW = 8,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          capture,
   input  logic [DW-1:0] mem_dq_i,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_dq_o,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr <= '0;
         mem_dq_o <= '0;
      end else if (accept) begin
         mem_addr <= req_addr;
         mem_dq_o <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= capture;
         if (capture) rsp_rdata <= mem_dq_i;
      end
   end

endmodule

// File: rtl/asram_seq.sv
module asram_seq
   import asram_seq_pkg::*;
#(
   parameter int AW        = 8,
   parameter int DW        = 16,
   parameter int SETUP_CYC = 2,
   parameter int PULSE_CYC = 3,
   parameter int WAIT_CYC  = 2,
   parameter int HOLD_CYC  = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_rdata,
   output logic          mem_cs_n,
   output logic          mem_we_n,
   output logic          mem_oe_n,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_dq_o,
   output logic          mem_dq_oe,
   input  logic [DW-1:0] mem_dq_i
);

   localparam int MAXC = int'(max_of4(SETUP_CYC, PULSE_CYC, WAIT_CYC, HOLD_CYC));
   localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;

   // R10: reject phase counts below one and empty widths
   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("asram_seq: SETUP_CYC must be at least 1");
   end
   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("asram_seq: PULSE_CYC must be at least 1");
   end
   if (WAIT_CYC < 1) begin : g_bad_wait
      $error("asram_seq: WAIT_CYC must be at least 1");
   end
   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("asram_seq: HOLD_CYC must be at least 1");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("asram_seq: AW and DW must be at least 1");
   end

   logic          load;
   logic [CW-1:0] load_val;
   logic          last;
   logic          accept;
   logic          capture;

   asram_phase_timer #(.CW(CW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .last     (last)
   );

   asram_seq_fsm #(
      .SETUP_CYC (SETUP_CYC),
      .PULSE_CYC (PULSE_CYC),
      .WAIT_CYC  (WAIT_CYC),
      .HOLD_CYC  (HOLD_CYC),
      .CW        (CW)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .last      (last),
      .load      (load),
      .load_val  (load_val),
      .accept    (accept),
      .capture   (capture),
      .ready     (req_ready),
      .cs_n      (mem_cs_n),
      .we_n      (mem_we_n),
      .oe_n      (mem_oe_n),
      .dq_oe     (mem_dq_oe)
   );

   asram_seq_dp #(.AW(AW), .DW(DW)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .capture   (capture),
      .mem_dq_i  (mem_dq_i),
      .mem_addr  (mem_addr),
      .mem_dq_o  (mem_dq_o),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata)
   );

endmodule

// File: rtl/asram_seq_chk.sv
module asram_seq_chk #(
   parameter int AW = 8,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_ready,
   input logic          rsp_valid,
   input logic          mem_cs_n,
   input logic          mem_we_n,
   input logic          mem_oe_n,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_dq_o,
   input logic          mem_dq_oe
);

   assert_no_dual_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_we_n && !mem_oe_n));

   assert_cs_covers_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n || !mem_oe_n) |-> !mem_cs_n);

   assert_addr_steady_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && !$past(req_ready)) |-> $stable(mem_addr));

   assert_write_drives_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_dq_oe);

   assert_wdata_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));

   assert_bus_free_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_dq_oe);

   assert_release_before_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_oe_n) |-> !$past(mem_dq_oe));

   assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_valid_at_oe_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $rose(mem_oe_n));

   assert_busy_while_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |-> !req_ready);

endmodule

bind asram_seq asram_seq_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .mem_cs_n  (mem_cs_n),
   .mem_we_n  (mem_we_n),
   .mem_oe_n  (mem_oe_n),
   .mem_addr  (mem_addr),
   .mem_dq_o  (mem_dq_o),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_seq_bench.sv
`timescale 1ns/1ps
module asram_seq_bench;

   localparam int AW = 8;
   localparam int DW = 16;
   localparam int S  = 2;
   localparam int P  = 3;
   localparam int W  = 2;
   localparam int H  = 1;
   localparam int NW = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, rsp_valid;
   logic [DW-1:0] rsp_rdata;
   logic          mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dq_o;

   always #4 clk = ~clk;

   // behavioural memory and bus resolution
   logic [DW-1:0] sram [NW];
   logic [DW-1:0] shadow [NW];
   wire           sram_drv = !mem_cs_n && !mem_oe_n && mem_we_n;
   wire [DW-1:0]  dq_bus = mem_dq_oe ? mem_dq_o : (sram_drv ? sram[mem_addr] : {DW{1'bz}});

   always @(posedge clk) begin
      if (!mem_cs_n && !mem_we_n) sram[mem_addr] <= dq_bus;
   end

   asram_seq #(
      .AW(AW), .DW(DW), .SETUP_CYC(S), .PULSE_CYC(P), .WAIT_CYC(W), .HOLD_CYC(H)
   ) u_asram_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
      .mem_dq_i(dq_bus)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [DW-1:0] exp_q [$];

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // monitor: sampled on the falling edge
   bit            p_rdy = 1, p_we = 1, p_oe = 1, p_dqoe = 0;
   logic [DW-1:0] p_dqo = '0;
   int            run_len, set_len, hold_len, we_len, oe_len;
   bit            seen_cs, run_wr;
   logic [AW-1:0] run_addr;

   always @(negedge clk) begin
      if (rst_n) begin
         if (!mem_cs_n || !mem_we_n || !mem_oe_n || mem_dq_oe) begin
            chk(!( !mem_we_n && !mem_oe_n), "R3 write strobe and output enable both low",
                {mem_we_n, mem_oe_n}, 2'b01);
            chk(!((!mem_we_n || !mem_oe_n) && mem_cs_n), "R3 chip select high during strobe",
                mem_cs_n, 0);
            chk(!(!mem_oe_n && mem_dq_oe), "R7 controller drives bus during read", mem_dq_oe, 0);
            chk(!(!mem_we_n && !mem_dq_oe), "R5 bus not driven during write strobe", mem_dq_oe, 1);
         end
         if (!mem_oe_n && p_oe)
            chk(!p_dqoe, "R7 bus drive in cycle before output enable", p_dqoe, 0);
         if (mem_dq_oe && p_dqoe)
            chk(mem_dq_o == p_dqo, "R6 write data changed while driven", mem_dq_o, p_dqo);

         if (!mem_we_n) we_len++;
         else if (!p_we) begin
            chk(we_len == P, "R5 write strobe width", we_len, P);
            we_len = 0;
         end
         if (!mem_oe_n) oe_len++;
         else if (!p_oe) begin
            chk(oe_len == W, "R7 read strobe width", oe_len, W);
            oe_len = 0;
         end

         if (!req_ready) begin
            if (p_rdy) begin
               run_len = 0; set_len = 0; hold_len = 0;
               seen_cs = 0; run_wr = 0; run_addr = mem_addr;
            end
            run_len++;
            if (mem_addr != run_addr)
               chk(0, "R2 address moved while busy", mem_addr, run_addr);
            if (mem_cs_n && !seen_cs) set_len++;
            if (!mem_cs_n && !seen_cs) begin
               chk(set_len == S, "R4 setup before chip select", set_len, S);
               seen_cs = 1;
            end
            if (!mem_we_n) run_wr = 1;
            if (mem_cs_n && seen_cs) hold_len++;
         end else if (!p_rdy) begin
            chk(run_len == S + (run_wr ? P : W) + H, "R9 busy length", run_len,
                S + (run_wr ? P : W) + H);
            chk(hold_len == H, "R6 hold after strobes", hold_len, H);
         end

         if (rsp_valid) begin
            chk(!p_oe && mem_oe_n, "R8 valid not at output enable rise", {p_oe, mem_oe_n}, 2'b01);
            if (exp_q.size() == 0) chk(0, "R8 unexpected response valid", rsp_rdata, 0);
            else begin
               logic [DW-1:0] e;
               e = exp_q.pop_front();
               chk(rsp_rdata == e, "R8 read data", rsp_rdata, e);
            end
         end

         p_rdy = req_ready; p_we = mem_we_n; p_oe = mem_oe_n;
         p_dqoe = mem_dq_oe; p_dqo = mem_dq_o;
      end
   end

   // driver
   task automatic op(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input int noise);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
      if (w) shadow[a] = d;
      else exp_q.push_back(shadow[a]);
      @(negedge clk);
      // R2: requests presented while busy must be ignored
      for (int i = 0; i < noise; i++) begin
         req_write = 1; req_addr = a + 1'b1; req_wdata = ~d;
         chk(!req_ready, "R2 ready high during noise request", req_ready, 0);
         @(negedge clk);
      end
      req_valid = 0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog expired actual=20000 cycles expected=fewer");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < NW; i++) begin
         sram[i]   = {i[7:0], ~i[7:0]};
         shadow[i] = {i[7:0], ~i[7:0]};
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(req_ready == 1, "R1 ready in reset", req_ready, 1);
      chk({mem_cs_n, mem_we_n, mem_oe_n} == 3'b111, "R1 strobes in reset",
          {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
      chk(mem_dq_oe == 0, "R1 bus drive in reset", mem_dq_oe, 0);
      chk(rsp_valid == 0, "R1 valid in reset", rsp_valid, 0);
      rst_n = 1;
      @(negedge clk);
      chk({req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe} == 5'b11110,
          "R1 idle after reset", {req_ready, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b11110);

      // writes at the address extremes and a middle word
      op(1, 8'h00, 16'h0000, 0);
      op(1, 8'hFF, 16'hFFFF, 0);
      op(1, 8'h5A, 16'h1234, 0);
      op(0, 8'h00, '0, 0);
      op(0, 8'hFF, '0, 0);
      op(0, 8'h5A, '0, 0);
      op(0, 8'h33, '0, 0);  // never written
      // R2: noisy requests during a write and a read
      op(1, 8'h10, 16'hBEEF, 3);
      op(0, 8'h11, '0, 0);
      op(0, 8'h10, '0, 3);
      op(0, 8'h11, '0, 0);
      // back-to-back write then read of the same word
      for (int i = 0; i < 8; i++) begin
         op(1, 8'h80 + 8'(i), 16'(i * 16'h1111) ^ 16'hA5C3, 0);
         op(0, 8'h80 + 8'(i), '0, 0);
      end
      op(0, 8'h81, '0, 0);

      repeat (12) @(negedge clk);
      chk(exp_q.size() == 0, "R8 responses outstanding", exp_q.size(), 0);
      chk(req_ready == 1, "R9 ready after last transaction", req_ready, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule